// File: doc/BRIEF.md
# Dual Interrupt Output Controller

This block turns two alarm sources, a time-of-day match and a watchdog timeout, into two interrupt lines for the rest of the system. Both sources share one 8-bit command register, which the host reaches over a simple read/write bus. The register latches a sticky flag for each source. It decides which source drives which line and the active sense of the second line. It masks each source on its own and picks between level and pulse signalling. It also holds a transfer-enable bit, which is passed straight to the clock-register logic next to the block.

In level mode a line stays asserted for as long as its source flag is set and the source is unmasked. In pulse mode each event starts a stretch timer that runs on a 1 ms tick. The line is held through a minimum number of tick periods and is then released, whatever the flag holds. The host clears a flag by writing 0 to its bit.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the command register reads 0x8C (transfer enable 1, both masks 1, all other bits 0). `irq_a_n` is 1, `irq_b` is 1 and `xfer_en` is 1.
- R2: The command register answers only at bus address `CMD_ADDR` (default 0x0B). Bits 7..2 read back as written. A read at any other address returns 0x00, and a write at any other address leaves the register unchanged.
- R3: `xfer_en` equals register bit 7 and follows a write to that bit from the next cycle on.
- R4: Bit 0 is the time-of-day flag and bit 1 is the watchdog flag. A source event sets its flag. Writing 0 to a flag clears it and writing 1 leaves it as it was. An event in the same cycle as a clearing write leaves the flag set.
- R5: Bit 2 masks the time-of-day source and bit 3 masks the watchdog source. A 1 keeps that source from asserting any output in either mode.
- R6: With bit 4 at 0 (level mode), an unmasked source asserts its line while its flag is 1. The line deasserts in the cycle after the flag is cleared.
- R7: With bit 4 at 1 (pulse mode), an event on an unmasked source asserts its line from the next cycle on. The line is released on the (`PULSE_TICKS`+1)-th `ms_tick` after the event, even while the flag is still set, so it is held for at least `PULSE_TICKS` full tick periods.
- R8: In pulse mode, a new event on a source whose pulse is running restarts its count of `PULSE_TICKS`+1 ticks.
- R9: When bit 6 is 1 the time-of-day source drives `irq_a_n` and the watchdog drives `irq_b`. When bit 6 is 0 the two are exchanged.
- R10: `irq_a_n` is always active-low. `irq_b` is active-high when bit 5 is 1 and active-low when bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_evt | input | 1 | Time-of-day alarm event strobe, one cycle |
| wdg_evt | input | 1 | Watchdog alarm event strobe, one cycle |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| irq_a_n | output | 1 | Interrupt line A, active-low |
| irq_b | output | 1 | Interrupt line B, active sense set by bit 5 |
| xfer_en | output | 1 | Transfer-enable level for the clock registers |

## Verification
The hardest state to reach from the ports is a pulse that is restarted while it is still running. To reach it, a second event must land after some ticks have been counted but before the release tick. The stimulus gets there by spacing events and ticks by hand, so the exact release tick can be predicted. The other hard case is a clearing write in the same cycle as an event. The bench drives that write and that event together in one cycle. The level-mode behaviour is swept over every combination of routing, B polarity, both masks and both flags. In each case the expected pin levels are computed from the routing and polarity rules.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

   // Command register layout, bit 7 down to bit 0.
   typedef struct packed {
      logic xfer_en;     // 7
      logic tod_on_a;    // 6
      logic b_high;      // 5
      logic pulse_mode;  // 4
      logic wdg_mask;    // 3
      logic tod_mask;    // 2
      logic wdg_flag;    // 1
      logic tod_flag;    // 0
   } cmd_t;

   localparam int unsigned NUM_SRC = 2;
   localparam int unsigned SRC_TOD = 0;
   localparam int unsigned SRC_WDG = 1;

   localparam cmd_t CMD_RESET = '{
      xfer_en:    1'b1,
      tod_on_a:   1'b0,
      b_high:     1'b0,
      pulse_mode: 1'b0,
      wdg_mask:   1'b1,
      tod_mask:   1'b1,
      wdg_flag:   1'b0,
      tod_flag:   1'b0
   };

endpackage

// File: rtl/irq_cmd_reg.sv
`timescale 1ns/1ps
module irq_cmd_reg
   import irq_route_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CMD_ADDR = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               rd,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [7:0]         wdata,
   input  logic [NUM_SRC-1:0] evt,
   output cmd_t               cmd,
   output logic [7:0]         rdata
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CMD_ADDR);

   logic hit;
   cmd_t q;
   cmd_t d;

   assign hit = (addr == HIT_ADDR);

   always_comb begin
      d = q;
      if (wr && hit) begin
         d.xfer_en    = wdata[7];
         d.tod_on_a   = wdata[6];
         d.b_high     = wdata[5];
         d.pulse_mode = wdata[4];
         d.wdg_mask   = wdata[3];
         d.tod_mask   = wdata[2];
         if (!wdata[1]) d.wdg_flag = 1'b0;
         if (!wdata[0]) d.tod_flag = 1'b0;
      end
      // events win over a clearing write
      if (evt[SRC_TOD]) d.tod_flag = 1'b1;
      if (evt[SRC_WDG]) d.wdg_flag = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= CMD_RESET;
      else        q <= d;
   end

   assign cmd   = q;
   assign rdata = (rd && hit) ? q : 8'h00;

endmodule

// File: rtl/irq_src_shaper.sv
`timescale 1ns/1ps
module irq_src_shaper #(
   parameter int unsigned PULSE_TICKS = 3,
   parameter int unsigned CNT_W       = $clog2(PULSE_TICKS + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic flag,
   input  logic mask,
   input  logic pulse_mode,
   input  logic tick,
   output logic active
);

   // One extra tick covers the partial period in which the event lands.
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_TICKS + 1);

   logic [CNT_W-1:0] cnt;
   logic             stretching;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (evt)                cnt <= LOAD;
      else if (tick && stretching) cnt <= cnt - 1'b1;
   end

   assign stretching = (cnt != '0);
   assign active     = !mask && (pulse_mode ? stretching : flag);

endmodule

// File: rtl/irq_pin_mux.sv
`timescale 1ns/1ps
module irq_pin_mux
   import irq_route_pkg::*;
(
   input  logic [NUM_SRC-1:0] active,
   input  logic               tod_on_a,
   input  logic               b_high,
   output logic               irq_a_n,
   output logic               irq_b
);

   logic a_src;
   logic b_src;

   always_comb begin
      if (tod_on_a) begin
         a_src = active[SRC_TOD];
         b_src = active[SRC_WDG];
      end else begin
         a_src = active[SRC_WDG];
         b_src = active[SRC_TOD];
      end
   end

   assign irq_a_n = !a_src;
   assign irq_b   = b_high ? b_src : !b_src;

endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
   import irq_route_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned CMD_ADDR    = 11,
   parameter int unsigned PULSE_TICKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tod_evt,
   input  logic              wdg_evt,
   input  logic              ms_tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_a_n,
   output logic              irq_b,
   output logic              xfer_en
);

   localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 2);

   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("PULSE_TICKS must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must be 1..16");
   end
   if (CMD_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("CMD_ADDR does not fit in ADDR_W bits");
   end

   cmd_t               cmd_q;
   logic [NUM_SRC-1:0] evt_v;
   logic [NUM_SRC-1:0] flag_v;
   logic [NUM_SRC-1:0] mask_v;
   logic [NUM_SRC-1:0] active_v;

   assign evt_v[SRC_TOD]  = tod_evt;
   assign evt_v[SRC_WDG]  = wdg_evt;
   assign flag_v[SRC_TOD] = cmd_q.tod_flag;
   assign flag_v[SRC_WDG] = cmd_q.wdg_flag;
   assign mask_v[SRC_TOD] = cmd_q.tod_mask;
   assign mask_v[SRC_WDG] = cmd_q.wdg_mask;

   irq_cmd_reg #(
      .ADDR_W   (ADDR_W),
      .CMD_ADDR (CMD_ADDR)
   ) u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .rd    (bus_rd),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .evt   (evt_v),
      .cmd   (cmd_q),
      .rdata (bus_rdata)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      irq_src_shaper #(
         .PULSE_TICKS (PULSE_TICKS),
         .CNT_W       (CNT_W)
      ) u_shape (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt        (evt_v[s]),
         .flag       (flag_v[s]),
         .mask       (mask_v[s]),
         .pulse_mode (cmd_q.pulse_mode),
         .tick       (ms_tick),
         .active     (active_v[s])
      );
   end

   irq_pin_mux u_mux (
      .active   (active_v),
      .tod_on_a (cmd_q.tod_on_a),
      .b_high   (cmd_q.b_high),
      .irq_a_n  (irq_a_n),
      .irq_b    (irq_b)
   );

   assign xfer_en = cmd_q.xfer_en;

endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk
   import irq_route_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CMD_ADDR = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tod_evt,
   input logic              wdg_evt,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              irq_a_n,
   input logic              irq_b,
   input logic              xfer_en,
   input cmd_t              cmd
);

   logic hit;
   assign hit = (bus_addr == ADDR_W'(CMD_ADDR));

   // R3
   xfer_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && hit |=> xfer_en == $past(bus_wdata[7]));

   // R4
   tod_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tod_evt |=> cmd.tod_flag);

   // R4
   wdg_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_evt |=> cmd.wdg_flag);

   // R5
   masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.tod_mask && cmd.wdg_mask |-> irq_a_n && (irq_b == !cmd.b_high));

   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd.pulse_mode && cmd.tod_flag && !cmd.tod_mask && cmd.tod_on_a
      |-> !irq_a_n);

   // R7
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tod_evt && !bus_wr && cmd.pulse_mode && !cmd.tod_mask && cmd.tod_on_a
      |=> !irq_a_n);

endmodule

bind irq_route_ctrl irq_route_chk #(
   .ADDR_W   (ADDR_W),
   .CMD_ADDR (CMD_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tod_evt   (tod_evt),
   .wdg_evt   (wdg_evt),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_a_n   (irq_a_n),
   .irq_b     (irq_b),
   .xfer_en   (xfer_en),
   .cmd       (cmd_q)
);

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;

   localparam int unsigned ADDR_W = 4;
   localparam int unsigned PT     = 3;
   localparam logic [3:0]  CA     = 4'hB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tod_evt = 1'b0, wdg_evt = 1'b0, ms_tick = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic irq_a_n, irq_b, xfer_en;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   irq_route_ctrl #(.ADDR_W(ADDR_W), .CMD_ADDR(11), .PULSE_TICKS(PT)) u_dut (
      .clk(clk), .rst_n(rst_n), .tod_evt(tod_evt), .wdg_evt(wdg_evt),
      .ms_tick(ms_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_a_n(irq_a_n), .irq_b(irq_b), .xfer_en(xfer_en)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic evt(input logic t, input logic w);
      @(negedge clk); tod_evt = t; wdg_evt = w;
      @(negedge clk); tod_evt = 1'b0; wdg_evt = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(CA, r);
      chk("R1 reg", r, 8'h8C);
      chk("R1 pins", {6'd0, irq_a_n, irq_b}, 8'h03);
      chk("R1 xfer", {7'd0, xfer_en}, 8'h01);

      // R2 address decode
      wr(4'hA, 8'h00);
      rd(CA, r);
      chk("R2 foreign write", r, 8'h8C);
      rd(4'hA, r);
      chk("R2 foreign read", r, 8'h00);

      // R3 transfer enable
      wr(CA, 8'h0C);
      chk("R3 xfer low", {7'd0, xfer_en}, 8'h00);
      wr(CA, 8'h8C);
      chk("R3 xfer high", {7'd0, xfer_en}, 8'h01);

      // R5 R6 R9 R10 level-mode sweep, with R2 R4 readback
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 4; f++) begin
            logic [3:0] cv;
            logic [1:0] fv;
            logic tact, wact, asrc, bsrc;
            cv = 4'(c);
            fv = 2'(f);
            wr(CA, {1'b1, cv[0], cv[1], 1'b0, cv[2], cv[3], 2'b00});
            evt(fv[0], fv[1]);
            tact = fv[0] & ~cv[3];
            wact = fv[1] & ~cv[2];
            asrc = cv[0] ? tact : wact;
            bsrc = cv[0] ? wact : tact;
            chk("R5 R6 R9 R10 pins", {6'd0, irq_a_n, irq_b},
                {6'd0, ~asrc, cv[1] ? bsrc : ~bsrc});
            rd(CA, r);
            chk("R2 R4 readback", r,
                {1'b1, cv[0], cv[1], 1'b0, cv[2], cv[3], fv[1], fv[0]});
         end
      end

      // R4 writing 1 has no effect on a clear flag; R6 clear deasserts
      wr(CA, 8'hC0);
      wr(CA, 8'hC3);
      rd(CA, r);
      chk("R4 write one", r, 8'hC0);
      evt(1'b1, 1'b0);
      chk("R6 level on", {7'd0, irq_a_n}, 8'h00);
      wr(CA, 8'hC1);
      chk("R4 write one keeps", {7'd0, irq_a_n}, 8'h00);
      wr(CA, 8'hC0);
      chk("R6 level off", {7'd0, irq_a_n}, 8'h01);

      // R4 event beats a clearing write in the same cycle
      @(negedge clk); bus_wr = 1'b1; bus_addr = CA; bus_wdata = 8'hC0; wdg_evt = 1'b1;
      @(negedge clk); bus_wr = 1'b0; wdg_evt = 1'b0;
      rd(CA, r);
      chk("R4 event wins", r, 8'hC2);

      // R7 pulse mode: tod on A, B active-high
      wr(CA, 8'hF0);
      evt(1'b1, 1'b0);
      chk("R7 pulse start", {7'd0, irq_a_n}, 8'h00);
      for (int k = 0; k < PT; k++) begin
         tick();
         chk("R7 pulse hold", {7'd0, irq_a_n}, 8'h00);
      end
      tick();
      chk("R7 pulse release", {7'd0, irq_a_n}, 8'h01);
      rd(CA, r);
      chk("R7 flag kept", r, 8'hF1);

      // R8 restart during a pulse
      evt(1'b1, 1'b0);
      tick(); tick();
      evt(1'b1, 1'b0);
      for (int k = 0; k < PT; k++) begin
         tick();
         chk("R8 restart hold", {7'd0, irq_a_n}, 8'h00);
      end
      tick();
      chk("R8 restart release", {7'd0, irq_a_n}, 8'h01);

      // R7 R9 R10 watchdog pulse on B, active-high
      evt(1'b0, 1'b1);
      chk("R9 R10 B pulse on", {7'd0, irq_b}, 8'h01);
      for (int k = 0; k <= PT; k++) tick();
      chk("R7 B pulse off", {7'd0, irq_b}, 8'h00);

      // R5 masked source in pulse mode
      wr(CA, 8'hF4);
      evt(1'b1, 1'b0);
      chk("R5 masked pulse", {6'd0, irq_a_n, irq_b}, 8'h02);

      summary();
      $finish;
   end

endmodule